// File: doc/BRIEF.md
# Registered ROM with Initialize Word

This block is a 2048-word by 8-bit read-only memory whose output passes through an edge-triggered register. On every rising clock edge the register takes the byte stored at the presented address. The address may then move on at once, so the next location is decoded while the previous byte stays steady at the outputs. The contents are filled through a small synchronous configuration write port, so no memory image file is needed. The same port sets one extra byte, the initialize word, which sits just past the data words.

An active-low initialize input forces the initialize word into the output register at once, without a clock. This makes power-up or time-out recovery and "jump start" start words possible. While the initialize word has never been written it reads as zero, so initialize behaves as a clear. An active-low enable gates the outputs. A parameter chooses between two enable modes: an immediate combinational enable, or an enable that is sampled on the clock together with the data. A disabled output shows a zero data bus with the valid flag low, which stands in for a floating bus.

Top module: `initword_rom`

## Requirements
- R1: On each rising clock edge with initialize high, `dout` takes the byte stored at `addr` as sampled on that edge; changes of `addr` between edges leave `dout` unchanged.
- R2: With `SYNC_EN`=0, `en_n` high makes `dout_vld` 0 and `en_n` low makes it 1 immediately, with no clock edge needed.
- R3: With `SYNC_EN`=1, `dout_vld` becomes the inverse of `en_n` as sampled on a rising edge, from that edge on.
- R4: With `SYNC_EN`=1, changes of `en_n` between rising edges have no effect on `dout` or `dout_vld`.
- R5: `init_n` low loads the initialize word into the output register at once, and the register keeps it across any clock edge while `init_n` stays low.
- R6: The initialize word reads 0x00 until it is written; writing 0xFF gives all ones, and any other pattern is loaded as written.
- R7: While `dout_vld` is 0, `dout` is 0x00.
- R8: With `SYNC_EN`=1, `init_n` low returns the registered enable to the active state, so `dout_vld` is 1 and the initialize word is visible.
- R9: A configuration write (`cfg_we` high on a rising edge) to `cfg_addr` 0x000..0x7FF stores the byte at that location, a write to 0x800 sets the initialize word, and a write above 0x800 changes nothing.
- R10: After `init_n` returns high, the initialize word stays at the outputs until the first rising edge, which loads the byte at `addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers act on its rising edge |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration address; 0x800 selects the initialize word |
| cfg_data | input | 8 | Configuration write data |
| addr | input | 11 | Read address |
| init_n | input | 1 | Active-low asynchronous initialize |
| en_n | input | 1 | Active-low output enable |
| dout | output | 8 | Registered data, 0 while disabled |
| dout_vld | output | 1 | High while the outputs are enabled |

## Verification
The hardest case is the interaction of initialize with a synchronous-mode enable that was last sampled inactive. To reach it, the bench disables both variants, then pulls initialize low while the enable is still high and checks at the ports that the registered variant becomes valid with the initialize word while the immediate variant stays dark until the enable drops. The bench also makes enable glitches that begin and end between two edges, and it checks that the registered variant keeps its state across each glitch while the immediate variant follows the enable.

// File: rtl/initword_rom.sv
module initword_rom #(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter bit SYNC_EN = 1'b0
) (
  input  logic              clk,
  input  logic              cfg_we,
  input  logic [ADDR_W:0]   cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [ADDR_W-1:0] addr,
  input  logic              init_n,
  input  logic              en_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] init_byte = '0;
  logic [DATA_W-1:0] rom_word;
  logic [DATA_W-1:0] q;
  logic              oe;

  wire to_mem  = cfg_we && !cfg_addr[ADDR_W];
  wire to_init = cfg_we && (cfg_addr == (ADDR_W+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (to_mem) mem[cfg_addr[ADDR_W-1:0]] <= cfg_data;
    if (to_init) init_byte <= cfg_data;
  end

  assign rom_word = mem[addr];

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) q <= init_byte;
    else         q <= rom_word;
  end

  generate
    if (SYNC_EN) begin : g_sync
      logic en_q;
      always_ff @(posedge clk or negedge init_n) begin
        if (!init_n) en_q <= 1'b0;
        else         en_q <= en_n;
      end
      assign oe = !en_q;
    end else begin : g_async
      assign oe = !en_n;
    end
  endgenerate

  assign dout     = oe ? q : '0;
  assign dout_vld = oe;
endmodule

module initword_rom_chk #(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter bit SYNC_EN = 1'b0
) (
  input logic              clk,
  input logic              cfg_we,
  input logic              init_n,
  input logic              en_n,
  input logic [DATA_W-1:0] rom_word,
  input logic [DATA_W-1:0] init_byte,
  input logic [DATA_W-1:0] dout,
  input logic              dout_vld
);
  // R7
  dark_bus_zero_chk: assert property (@(posedge clk) disable iff (!init_n)
    !dout_vld |-> dout == '0);

  // R1
  capture_rom_chk: assert property (@(posedge clk) disable iff (!init_n)
    ($past(init_n) && !$past(cfg_we) && dout_vld) |-> dout == $past(rom_word));

  // R5
  init_hold_chk: assert property (@(posedge clk)
    (!init_n && $past(!init_n) && !$past(cfg_we) && dout_vld) |-> dout == init_byte);

  generate
    if (SYNC_EN) begin : g_sync_chk
      // R3
      sampled_enable_chk: assert property (@(posedge clk) disable iff (!init_n)
        $past(init_n) |-> dout_vld == !$past(en_n));
      // R8
      init_enables_chk: assert property (@(posedge clk)
        !init_n |-> dout_vld);
    end else begin : g_async_chk
      // R2
      direct_enable_chk: assert property (@(posedge clk)
        dout_vld == !en_n);
    end
  endgenerate
endmodule

bind initword_rom initword_rom_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_EN(SYNC_EN)) u_chk (.*);

// File: tb/test_initword_rom.sv
`timescale 1ns/1ps
module test_initword_rom;
  logic        clk = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [7:0]  cfg_data = '0;
  logic [10:0] addr = '0;
  logic        init_n = 1'b0;
  logic        en_n = 1'b0;
  logic [7:0]  dout_a, dout_s;
  logic        vld_a, vld_s;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  initword_rom #(.SYNC_EN(1'b0)) i_initword_rom (
    .clk(clk), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .addr(addr), .init_n(init_n), .en_n(en_n), .dout(dout_a), .dout_vld(vld_a));

  initword_rom #(.SYNC_EN(1'b1)) i_initword_rom_sync (
    .clk(clk), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .addr(addr), .init_n(init_n), .en_n(en_n), .dout(dout_s), .dout_vld(vld_s));

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + (a >> 3)) & 8'hFF);
  endfunction

  task automatic chk(string rq, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic both(string rq, logic [7:0] d, logic v);
    chk({rq, " async data"}, dout_a, d);
    chk({rq, " async valid"}, {7'b0, vld_a}, {7'b0, v});
    chk({rq, " sync data"}, dout_s, d);
    chk({rq, " sync valid"}, {7'b0, vld_s}, {7'b0, v});
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg_wr(logic [11:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic init_pulse();
    init_n = 1'b0;
    #0.2;
    tick();
    init_n = 1'b1;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 30000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) tick();
    // R6 unwritten init word acts as clear; R8 sync enable active under init
    both("R6 clear", 8'h00, 1'b1);
    init_n = 1'b1;
    tick();

    for (int a = 0; a < 2048; a++) cfg_wr(12'(a), pat(a));
    cfg_wr(12'h800, 8'hA5);

    // R5 immediate load without clock, held across edges
    addr = 11'd5;
    init_n = 1'b0;
    #0.2;
    both("R5 immediate", 8'hA5, 1'b1);
    tick(); tick();
    both("R5 held over edge", 8'hA5, 1'b1);
    init_n = 1'b1;
    #0.2;
    // R10 stays until next edge
    both("R10 before edge", 8'hA5, 1'b1);
    tick();
    both("R10 first edge", pat(5), 1'b1);

    // R1 full sweep with address change between edges
    for (int a = 0; a < 2048; a++) begin
      addr = 11'(a);
      tick();
      both("R1 read", pat(a), 1'b1);
      addr = ~11'(a);
      #1;
      both("R1 stable", pat(a), 1'b1);
    end

    // R9 writes above 0x800 ignored
    cfg_wr(12'h801, 8'h3C);
    cfg_wr(12'hFFF, 8'h11);
    cfg_wr(12'hC05, 8'h77);
    init_pulse();
    both("R9 init word kept", 8'hA5, 1'b1);
    addr = 11'd1; tick();
    both("R9 word 1 kept", pat(1), 1'b1);
    addr = 11'd5; tick();
    both("R9 word 5 kept", pat(5), 1'b1);
    addr = 11'h7FF; tick();
    both("R9 top word", pat(2047), 1'b1);

    // R6 preset and arbitrary pattern
    cfg_wr(12'h800, 8'hFF);
    init_pulse();
    both("R6 preset", 8'hFF, 1'b1);
    cfg_wr(12'h800, 8'h5A);
    init_pulse();
    both("R6 pattern", 8'h5A, 1'b1);

    // R2 R3 R4 R7 enable behaviour
    addr = 11'd3; tick();
    both("R1 before enable", pat(3), 1'b1);
    en_n = 1'b1;
    #0.2;
    chk("R2 async off valid", {7'b0, vld_a}, 8'h00);
    chk("R7 async off data", dout_a, 8'h00);
    chk("R4 sync valid kept", {7'b0, vld_s}, 8'h01);
    chk("R4 sync data kept", dout_s, pat(3));
    tick();
    chk("R3 sync off valid", {7'b0, vld_s}, 8'h00);
    chk("R7 sync off data", dout_s, 8'h00);
    en_n = 1'b0;
    #0.2;
    chk("R2 async on valid", {7'b0, vld_a}, 8'h01);
    chk("R2 async on data", dout_a, pat(3));
    chk("R4 sync still off", {7'b0, vld_s}, 8'h00);
    tick();
    both("R3 sync back on", pat(3), 1'b1);

    en_n = 1'b1; #0.3; en_n = 1'b0;
    tick();
    both("R4 high glitch ignored", pat(3), 1'b1);
    en_n = 1'b1;
    tick();
    chk("R3 sync off again", {7'b0, vld_s}, 8'h00);
    en_n = 1'b0; #0.3; en_n = 1'b1;
    tick();
    chk("R4 low glitch ignored", {7'b0, vld_s}, 8'h00);
    chk("R7 sync dark data", dout_s, 8'h00);

    // R8 init re-activates sync enable; async waits for enable
    init_n = 1'b0;
    #0.2;
    chk("R8 sync valid", {7'b0, vld_s}, 8'h01);
    chk("R8 sync init word", dout_s, 8'h5A);
    chk("R7 async dark", dout_a, 8'h00);
    en_n = 1'b0;
    #0.2;
    chk("R5 async shows init", dout_a, 8'h5A);
    tick();
    init_n = 1'b1;
    addr = 11'd9;
    tick();
    both("R10 after release", pat(9), 1'b1);

    finish_up();
  end
endmodule